// File: doc/BRIEF.md
# Addressed SPI Command Front End

This block is the serial front end of a multi-channel register device. It runs on a system clock and watches four serial lines: a serial clock, an active-low select, an active-low pause input and a data input. Data bits are taken on each rising serial-clock edge, most significant bit first. Return data leaves on falling edges. The serial lines are expected to be synchronous to the system clock and to change well away from its edges.

Each transaction opens when select falls. The first byte must name this device: a fixed type code in its upper nibble, two zero bits, and the value of two strap pins in its low bits. If it does not match, the device stays silent until select rises again. The second byte is a command. It carries an opcode, a channel number and a register number, and is passed to a register bank with a one-cycle strobe.

Later bytes depend on the opcode class. In a write, each data byte goes to the bank with its own strobe. In a read, the bank is asked for a byte at every byte boundary, and that byte is shifted out. When select rises, the bank receives an end strobe and a flag that says whether the command arrived whole. While the pause input is low, the serial sequence is frozen in place.

Top module: `spi_cmd_front`

## Requirements
- R1: While `cs_n` is high, `so_oe` is 0 and none of `cmd_valid`, `wr_valid` or `rd_req` is asserted. `so_oe` is also 0 in reset.
- R2: After reset, no byte is decoded until a high-to-low transition of `cs_n` has been seen. If `cs_n` is already low when reset ends, that select period produces no strobes.
- R3: The first byte after `cs_n` falls is accepted only when it equals `{DEV_TYPE, 2'b00, addr_strap}`, sent MSB first. `DEV_TYPE` defaults to 4'b0101. On a mismatch, all later bytes in the same select period produce no strobes, even if one of them is a valid identification byte.
- R4: In the second byte, bits 7:4 appear on `cmd_op`, bits 3:2 on `cmd_chan` and bits 1:0 on `cmd_reg`. `cmd_valid` pulses for exactly one clock cycle.
- R5: When opcode bits 7:6 are 2'b11 (the write class), each of the next `WR_BYTES` bytes pulses `wr_valid` with that byte on `wr_data`. Any byte after those produces no `wr_valid`.
- R6: When `cs_n` rises after an accepted command, `done` pulses once. `done_ok` is 1 only if the write class received all `WR_BYTES` bytes; for every other class, `done_ok` is 1. A select period with no accepted command produces no `done`.
- R7: When opcode bits 7:6 are 2'b10 (the read class), `rd_req` pulses at the end of the command byte and at the end of every later byte. `rd_data` is loaded on the following falling serial-clock edge and shifted out on `so`, MSB first, one bit per falling edge. During the read, `so_oe` is 1 while `cs_n` is low and `hold_n` is high.
- R8: While `hold_n` is low, serial-clock edges are ignored and `so_oe` is 0. When `hold_n` returns high, shifting resumes at the same bit position.
- R9: A partial byte that is pending when `cs_n` rises is discarded. The next transaction starts at bit 7 of a new identification byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause |
| si | input | 1 | Serial data in |
| addr_strap | input | 2 | Strapped device address |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| cmd_valid | output | 1 | Command byte strobe |
| cmd_op | output | 4 | Decoded opcode |
| cmd_chan | output | 2 | Channel pointer |
| cmd_reg | output | 2 | Register pointer |
| wr_valid | output | 1 | Write data strobe |
| wr_data | output | 8 | Write data byte |
| rd_req | output | 1 | Read data request |
| rd_data | input | 8 | Read data from the bank |
| done | output | 1 | End-of-transaction strobe |
| done_ok | output | 1 | Command was received whole |

## Verification
The bench builds the block with `WR_BYTES` = 2 instead of the default of 1, and with the strap pins at 2'b10. With two required bytes, the bench can tell a short write (one byte received, so `done_ok` is 0) from a full one. It can also check that a third, surplus byte is dropped, cases that a single-byte setting would merge into one. The type code keeps its default value, so the identification vectors exercise the fixed nibble, the two zero bits and the strap comparison one at a time.

// File: rtl/spi_cmd_front.sv
module spi_cmd_front #(
  parameter logic [3:0] DEV_TYPE = 4'b0101,
  parameter int WR_BYTES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       hold_n,
  input  logic       si,
  input  logic [1:0] addr_strap,
  output logic       so,
  output logic       so_oe,
  output logic       cmd_valid,
  output logic [3:0] cmd_op,
  output logic [1:0] cmd_chan,
  output logic [1:0] cmd_reg,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       rd_req,
  input  logic [7:0] rd_data,
  output logic       done,
  output logic       done_ok
);
  localparam int DCW = $clog2(WR_BYTES + 2);
  localparam logic [DCW-1:0] WR_NEED = DCW'(WR_BYTES);

  typedef enum logic [1:0] {P_OFF, P_ID, P_INS, P_DAT} phase_t;

  phase_t         ph;
  logic           sck_q, cs_q;
  logic [2:0]     bit_cnt;
  logic [6:0]     sh_in;
  logic [7:0]     sh_out;
  logic [DCW-1:0] dat_cnt;
  logic           is_wr, is_rd, cmd_seen, complete, ld_pend;

  wire       live     = ~cs_n & hold_n;
  wire       rise     = live & sck & ~sck_q;
  wire       fall     = live & ~sck & sck_q;
  wire       cs_fall  = cs_q & ~cs_n;
  wire       cs_rise  = ~cs_q & cs_n;
  wire       last_bit = rise & (bit_cnt == 3'd7);
  wire [7:0] rx       = {sh_in, si};
  wire       id_ok    = rx == {DEV_TYPE, 2'b00, addr_strap};

  assign so    = sh_out[7];
  assign so_oe = live & is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= P_OFF;
      sck_q     <= 1'b0;
      cs_q      <= 1'b0;
      bit_cnt   <= '0;
      sh_in     <= '0;
      sh_out    <= '0;
      dat_cnt   <= '0;
      is_wr     <= 1'b0;
      is_rd     <= 1'b0;
      cmd_seen  <= 1'b0;
      complete  <= 1'b0;
      ld_pend   <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_chan  <= '0;
      cmd_reg   <= '0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      rd_req    <= 1'b0;
      done      <= 1'b0;
      done_ok   <= 1'b0;
    end else begin
      sck_q     <= sck;
      cs_q      <= cs_n;
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      rd_req    <= 1'b0;
      done      <= 1'b0;
      done_ok   <= 1'b0;
      if (cs_n) begin
        ph       <= P_OFF;
        bit_cnt  <= '0;
        is_wr    <= 1'b0;
        is_rd    <= 1'b0;
        ld_pend  <= 1'b0;
        cmd_seen <= 1'b0;
        complete <= 1'b0;
        if (cs_rise && cmd_seen) begin
          done    <= 1'b1;
          done_ok <= complete;
        end
      end else if (cs_fall) begin
        ph      <= P_ID;
        bit_cnt <= '0;
      end else begin
        if (rise) begin
          sh_in   <= rx[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (last_bit) begin
          case (ph)
            P_ID: ph <= id_ok ? P_INS : P_OFF;
            P_INS: begin
              cmd_op    <= rx[7:4];
              cmd_chan  <= rx[3:2];
              cmd_reg   <= rx[1:0];
              cmd_valid <= 1'b1;
              cmd_seen  <= 1'b1;
              ph        <= P_DAT;
              dat_cnt   <= '0;
              is_wr     <= rx[7:6] == 2'b11;
              is_rd     <= rx[7:6] == 2'b10;
              complete  <= rx[7:6] != 2'b11;
              if (rx[7:6] == 2'b10) begin
                rd_req  <= 1'b1;
                ld_pend <= 1'b1;
              end
            end
            P_DAT: begin
              if (is_wr && !complete) begin
                wr_valid <= 1'b1;
                wr_data  <= rx;
                dat_cnt  <= dat_cnt + 1'b1;
                if (dat_cnt + 1'b1 == WR_NEED) complete <= 1'b1;
              end else if (is_rd) begin
                rd_req  <= 1'b1;
                ld_pend <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (fall && is_rd) begin
          if (ld_pend) begin
            sh_out  <= rd_data;
            ld_pend <= 1'b0;
          end else begin
            sh_out <= {sh_out[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

module spi_cmd_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic hold_n,
  input logic so_oe,
  input logic cmd_valid,
  input logic wr_valid,
  input logic rd_req,
  input logic done,
  input logic done_ok
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> (!so_oe && !cmd_valid && !wr_valid && !rd_req));
  // R4
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R5
  wr_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && cmd_valid));
  // R6
  done_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cs_n));
  // R6
  ok_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> done);
  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && $past(!hold_n)) |-> (!so_oe && !cmd_valid && !wr_valid && !rd_req));
endmodule

bind spi_cmd_front spi_cmd_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
  .cmd_valid(cmd_valid), .wr_valid(wr_valid), .rd_req(rd_req),
  .done(done), .done_ok(done_ok)
);

// File: tb/spi_cmd_front_test.sv
module spi_cmd_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, hold_n = 1'b1, si = 1'b0;
  logic [1:0] strap = 2'b10;
  logic so, so_oe, cmd_valid, wr_valid, rd_req, done, done_ok;
  logic [3:0] cmd_op;
  logic [1:0] cmd_chan, cmd_reg;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;

  always #4 clk = ~clk;

  spi_cmd_front #(.WR_BYTES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .addr_strap(strap), .so(so), .so_oe(so_oe), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_reg(cmd_reg),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
    .done(done), .done_ok(done_ok)
  );

  int total = 0, bad = 0;
  int cmd_n, wr_n, rq_n, done_n, bank_idx = 0;
  logic [7:0] l_ins, l_wr;
  logic l_ok, oe_in_hold, finished = 1'b0;

  always @(negedge clk) begin
    if (cmd_valid) begin cmd_n++; l_ins = {cmd_op, cmd_chan, cmd_reg}; end
    if (wr_valid) begin wr_n++; l_wr = wr_data; end
    if (done) begin done_n++; l_ok = done_ok; end
    if (rd_req) begin
      rq_n++;
      rd_data <= 8'h96 + 8'(8'h11 * bank_idx);
      bank_idx++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    cmd_n = 0; wr_n = 0; rq_n = 0; done_n = 0; l_ok = 1'b0; l_ins = 8'h00; l_wr = 8'h00;
  endtask

  task automatic xfer(input logic [7:0] b, input int nb, input int hold_at, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      if (i == hold_at) begin
        @(negedge clk) hold_n = 1'b0;
        repeat (2) @(negedge clk);
        oe_in_hold = so_oe;
        for (int k = 0; k < 2; k++) begin
          sck = 1'b1; si = ~si; repeat (3) @(negedge clk);
          sck = 1'b0; repeat (3) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (2) @(negedge clk);
      end
      @(negedge clk) si = b[i];
      repeat (3) @(negedge clk);
      r[i] = so;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // {id, ins, d0, d1, ndata[1:0], cmd, done, ok, wr[2:0]}
  localparam logic [39:0] VEC [8] = '{
    40'h52_C5_3C_81_BA,
    40'h52_D0_11_00_71,
    40'h53_C0_11_22_80,
    40'h62_C0_11_22_80,
    40'h56_C0_11_22_80,
    40'h52_3A_00_00_38,
    40'h52_F2_01_02_BA,
    40'h52_C8_00_00_30
  };

  initial begin
    logic [7:0] r, r1, r2;
    repeat (3) @(negedge clk);
    check("R1 reset so_oe", so_oe, 0);
    rst_n = 1'b1;
    clr();
    xfer(8'h52, 8, -1, r); xfer(8'hC5, 8, -1, r); xfer(8'h3C, 8, -1, r);
    desel();
    check("R2 no cmd without cs fall", cmd_n, 0);
    check("R2 no done without cs fall", done_n, 0);
    check("R1 so_oe while deselected", so_oe, 0);

    for (int v = 0; v < 8; v++) begin
      logic [39:0] e;
      e = VEC[v];
      clr(); sel();
      xfer(e[39:32], 8, -1, r); xfer(e[31:24], 8, -1, r);
      if (e[7:6] > 0) xfer(e[23:16], 8, -1, r);
      if (e[7:6] > 1) xfer(e[15:8], 8, -1, r);
      desel();
      check($sformatf("R3 vec%0d cmd count", v), cmd_n, e[5]);
      check($sformatf("R6 vec%0d done count", v), done_n, e[4]);
      if (e[4]) check($sformatf("R6 vec%0d done_ok", v), l_ok, e[3]);
      check($sformatf("R5 vec%0d wr count", v), wr_n, e[2:0]);
      if (e[5]) check($sformatf("R4 vec%0d fields", v), l_ins, e[31:24]);
      if (e[2:0] == 3'd2) check($sformatf("R5 vec%0d last data", v), l_wr, e[15:8]);
    end

    clr(); sel();
    xfer(8'h53, 8, -1, r); xfer(8'h52, 8, -1, r); xfer(8'h3A, 8, -1, r);
    desel();
    check("R3 no retry after mismatch", cmd_n, 0);

    clr(); sel();
    xfer(8'hFF, 3, -1, r);
    desel(); sel();
    xfer(8'h52, 8, -1, r); xfer(8'h2D, 8, -1, r);
    desel();
    check("R9 partial byte discarded", cmd_n, 1);
    check("R9 fields after partial", l_ins, 8'h2D);

    clr(); sel();
    xfer(8'h52, 8, -1, r); xfer(8'hC1, 8, -1, r);
    xfer(8'h10, 8, -1, r); xfer(8'h20, 8, -1, r); xfer(8'h30, 8, -1, r);
    desel();
    check("R5 surplus byte dropped", wr_n, 2);
    check("R5 last data kept", l_wr, 8'h20);
    check("R6 full write ok", l_ok, 1);

    clr(); sel();
    xfer(8'h52, 8, 3, r); xfer(8'h3A, 8, -1, r);
    desel();
    check("R8 hold inside id byte", cmd_n, 1);
    check("R8 fields after hold", l_ins, 8'h3A);

    clr(); sel();
    xfer(8'h52, 8, -1, r); xfer(8'h8B, 8, -1, r);
    @(negedge clk);
    check("R7 so_oe in read", so_oe, 1);
    xfer(8'h00, 8, 4, r1);
    check("R8 so_oe in hold", oe_in_hold, 0);
    xfer(8'h00, 8, -1, r2);
    desel();
    check("R7 first read byte", r1, 8'h96);
    check("R7 second read byte", r2, 8'hA7);
    check("R7 request count", rq_n, 3);
    check("R4 read fields", l_ins, 8'h8B);
    check("R6 read done_ok", l_ok, 1);
    check("R1 so_oe after read", so_oe, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule